// File: doc/BRIEF.md
# Timer Prescaler with Synchronization Hold

This block produces the count-enable for an 8-bit timer/counter. A free-running 10-bit divider supplies one-cycle enable strobes at 1/8, 1/64, 1/256 and 1/1024 of the system clock. A pin input passes through a two-stage synchronizer and an edge detector, so the timer can also count rising or falling edges of an outside signal. A 3-bit clock selector picks one of these sources, the plain system clock, or nothing. The result is `cnt_en`, high for one system cycle per timer increment.

A control byte at I/O address 0x23 holds two bits: a hold-mode bit (bit 7) and a divider-restart bit (bit 0). Writing the restart bit clears the divider. Hardware drops the restart bit on the next cycle. While hold mode is set, the restart bit stays up, so the timer is frozen while software sets it up. Writing hold mode back to 0 releases the restart bit, and counting resumes from a cleared divider. A small state machine holds the two bits as four named states:

- `ST_RUN`: hold 0, restart 0.
- `ST_PULSE`: hold 0, restart 1.
- `ST_ARMED`: hold 1, restart 0.
- `ST_HOLD`: hold 1, restart 1.

A bus write to the control address moves the machine straight to the state named by written bits {7,0}. With no write, `ST_PULSE` falls back to `ST_RUN`, and every other state stays where it is.

Top module: `tmr_prescaler`

## Requirements
- R1: After reset the control byte reads 0x00 and `cnt_en` is low.
- R2: Reading address 0x23 returns hold mode in bit 7, restart in bit 0, and zeros in bits 6..1. Other addresses read 0x00, and writes to them change nothing.
- R3: Writing a byte with bit 0 = 1 and bit 7 = 0 reads back 0x01 for exactly one cycle and 0x00 after that. It also clears the divider.
- R4: Writing 0x81 keeps the control byte at 0x81 until the next write to the control address.
- R5: Writing bit 7 = 0 and bit 0 = 0 from hold ends the restart at once. The divider starts from zero, so the first 1/8 strobe comes in the 8th cycle after the write.
- R6: A bus write arriving in the cycle where the restart bit would clear itself takes priority over the automatic clear.
- R7: Select 000 gives no pulses. Select 001 gives a pulse every cycle.
- R8: Selects 010, 011, 100 and 101 pulse for one cycle every 8, 64, 256 and 1024 cycles. After a restart write with hold 0, the first pulse comes N cycles after the cycle in which restart reads 1.
- R9: Select 111 pulses once per rising pin edge and select 110 once per falling pin edge. The pulse appears in the second sampled cycle after the pin changes.
- R10: The pin path is never divided: every qualifying edge gives exactly one pulse.
- R11: While the restart bit is 1, `cnt_en` stays low for every select value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe |
| addr | input | 6 | Bus I/O address |
| wdata | input | 8 | Bus write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| clk_sel | input | 3 | Count source select |
| ext_clk | input | 1 | Outside clock pin, asynchronous |
| cnt_en | output | 1 | One-cycle count enable for the timer |

## Verification
Two functions can land in the same cycle: the automatic clear of the restart bit, and a new bus write to the control byte. The bench provokes this by writing 0x01 and then 0x81 on consecutive cycles. It expects the byte to settle at 0x81 and not at 0x00, and expects no enable pulses during that time. A second overlap comes from a write that drops hold mode in `ST_HOLD`. That single write must end the restart and start the divider from zero, which the bench judges by where the first 1/8 strobe falls.

// File: rtl/tps_pkg.sv
package tps_pkg;

    // Encoding is {hold, restart} so a write maps straight to a state.
    typedef enum logic [1:0] {
        ST_RUN   = 2'b00,
        ST_PULSE = 2'b01,
        ST_ARMED = 2'b10,
        ST_HOLD  = 2'b11
    } ctl_state_t;

    typedef enum logic [2:0] {
        CS_OFF      = 3'b000,
        CS_SYS      = 3'b001,
        CS_D8       = 3'b010,
        CS_D64      = 3'b011,
        CS_D256     = 3'b100,
        CS_D1024    = 3'b101,
        CS_EXT_FALL = 3'b110,
        CS_EXT_RISE = 3'b111
    } csel_t;

    localparam int NUM_TAPS = 4;

    // log2 of each divide ratio, tap index 0..3
    function automatic int tap_log2(input int idx);
        case (idx)
            0:       return 3;
            1:       return 6;
            2:       return 8;
            default: return 10;
        endcase
    endfunction

endpackage

// File: rtl/tps_ctrl_fsm.sv
module tps_ctrl_fsm
    import tps_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_hit,
    input  logic wr_hold,
    input  logic wr_restart,
    output logic hold_q,
    output logic restart_q
);

    ctl_state_t state, state_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        if (wr_hit) begin
            state_n = ctl_state_t'({wr_hold, wr_restart});
        end else begin
            unique case (state)
                ST_RUN:   state_n = ST_RUN;
                ST_PULSE: state_n = ST_RUN;
                ST_ARMED: state_n = ST_ARMED;
                ST_HOLD:  state_n = ST_HOLD;
            endcase
        end
    end

    always_comb begin
        hold_q    = 1'b0;
        restart_q = 1'b0;
        unique case (state)
            ST_RUN:   begin hold_q = 1'b0; restart_q = 1'b0; end
            ST_PULSE: begin hold_q = 1'b0; restart_q = 1'b1; end
            ST_ARMED: begin hold_q = 1'b1; restart_q = 1'b0; end
            ST_HOLD:  begin hold_q = 1'b1; restart_q = 1'b1; end
        endcase
    end

endmodule

// File: rtl/tps_div.sv
module tps_div
    import tps_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    output logic [NUM_TAPS-1:0] tap
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else          cnt <= cnt + 1'b1;
    end

    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        localparam int L = tap_log2(g);
        assign tap[g] = &cnt[L-1:0];
    end

endmodule

// File: rtl/tps_ext_edge.sv
module tps_ext_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);

    logic [SYNC_STAGES-1:0] sync_r;
    logic                   hist;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_r <= '0;
            hist   <= 1'b0;
        end else begin
            sync_r <= {sync_r[SYNC_STAGES-2:0], pin};
            hist   <= sync_r[SYNC_STAGES-1];
        end
    end

    assign rise =  sync_r[SYNC_STAGES-1] & ~hist;
    assign fall = ~sync_r[SYNC_STAGES-1] &  hist;

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tps_pkg::*;
#(
    parameter int             ADDR_W    = 6,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 6'h23,
    parameter int             DIV_W     = 10,
    parameter int             SYNC_STG  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic [2:0]        clk_sel,
    input  logic              ext_clk,
    output logic              cnt_en
);

    localparam int HOLD_BIT    = 7;
    localparam int RESTART_BIT = 0;

    logic                hit;
    logic                wr_hit;
    logic                hold_q;
    logic                restart_q;
    logic [NUM_TAPS-1:0] tap;
    logic                ext_rise;
    logic                ext_fall;
    logic                en_raw;

    assign hit    = (addr == CTRL_ADDR);
    assign wr_hit = wr_en & hit;

    tps_ctrl_fsm u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_hit     (wr_hit),
        .wr_hold    (wdata[HOLD_BIT]),
        .wr_restart (wdata[RESTART_BIT]),
        .hold_q     (hold_q),
        .restart_q  (restart_q)
    );

    tps_div #(.CNT_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (restart_q),
        .tap   (tap)
    );

    tps_ext_edge #(.SYNC_STAGES(SYNC_STG)) u_ext (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (ext_clk),
        .rise  (ext_rise),
        .fall  (ext_fall)
    );

    always_comb begin
        en_raw = 1'b0;
        unique case (csel_t'(clk_sel))
            CS_OFF:      en_raw = 1'b0;
            CS_SYS:      en_raw = 1'b1;
            CS_D8:       en_raw = tap[0];
            CS_D64:      en_raw = tap[1];
            CS_D256:     en_raw = tap[2];
            CS_D1024:    en_raw = tap[3];
            CS_EXT_FALL: en_raw = ext_fall;
            CS_EXT_RISE: en_raw = ext_rise;
        endcase
    end

    assign cnt_en = en_raw & ~restart_q;

    always_comb begin
        rdata = 8'h00;
        if (hit) begin
            rdata[HOLD_BIT]    = hold_q;
            rdata[RESTART_BIT] = restart_q;
        end
    end

endmodule

// File: rtl/tps_checker.sv
module tps_checker #(
    parameter int                ADDR_W    = 6,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 6'h23
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        wdata,
    input logic [2:0]        clk_sel,
    input logic              cnt_en,
    input logic              hold_q,
    input logic              restart_q
);

    logic wr_hit;
    assign wr_hit = wr_en && (addr == CTRL_ADDR);

    a_r3_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_q && !hold_q && !wr_hit) |=> !restart_q);

    a_r4_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_q && hold_q && !wr_hit) |=> (restart_q && hold_q));

    a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !wdata[7] && !wdata[0]) |=> (!restart_q && !hold_q));

    a_r6_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && wdata[0]) |=> restart_q);

    a_r7_off: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == 3'b000) |-> !cnt_en);

    a_r7_sys: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == 3'b001 && !restart_q) |-> cnt_en);

    a_r8_single: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel inside {3'b010, 3'b011, 3'b100, 3'b101} && cnt_en)
        |=> !(cnt_en && $stable(clk_sel)));

    a_r11_gate: assert property (@(posedge clk) disable iff (!rst_n)
        restart_q |-> !cnt_en);

endmodule

bind tmr_prescaler tps_checker #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .clk_sel   (clk_sel),
    .cnt_en    (cnt_en),
    .hold_q    (hold_q),
    .restart_q (restart_q)
);

// File: tb/tb_tmr_prescaler.sv
module tb_tmr_prescaler;

    localparam logic [5:0] CTRL = 6'h23;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [5:0] addr = CTRL;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [2:0] clk_sel = 3'b000;
    logic       ext_clk = 1'b0;
    logic       cnt_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tmr_prescaler dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .clk_sel (clk_sel),
        .ext_clk (ext_clk),
        .cnt_en  (cnt_en)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic bus_wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = CTRL;
    endtask

    // Sample n cycles starting at the current negedge; index 0 is now.
    task automatic count(input int n, output int first, output int total);
        first = -1; total = 0;
        for (int i = 0; i < n; i++) begin
            if (i > 0) @(negedge clk);
            #1;
            if (cnt_en) begin
                if (first < 0) first = i;
                total++;
            end
        end
    endtask

    task automatic toggle_ext(input int periods, output int total);
        total = 0;
        for (int p = 0; p < periods; p++) begin
            for (int ph = 0; ph < 2; ph++) begin
                ext_clk = (ph == 0);
                for (int j = 0; j < 3; j++) begin
                    #1;
                    if (cnt_en) total++;
                    @(negedge clk);
                end
            end
        end
    endtask

    task automatic t_reset;
        #1;
        check("R1 reset readback", rdata, 8'h00);
        check("R1 reset cnt_en", cnt_en, 0);
    endtask

    task automatic t_off_sys;
        int f, t;
        clk_sel = 3'b000;
        count(20, f, t);
        check("R7 select off pulses", t, 0);
        clk_sel = 3'b001;
        @(negedge clk);
        count(20, f, t);
        check("R7 select sys pulses", t, 20);
    endtask

    task automatic t_other_addr;
        int f, t;
        bus_wr(6'h22, 8'h81);
        addr = 6'h22; #1;
        check("R2 other address reads zero", rdata, 8'h00);
        addr = CTRL; #1;
        check("R2 other address write ignored", rdata, 8'h00);
        count(5, f, t);
        check("R2 counting unaffected", t, 5);
    endtask

    task automatic t_self_clear;
        int f, t;
        clk_sel = 3'b001;
        bus_wr(CTRL, 8'h7F);
        #1;
        check("R2 bits 6..1 read zero", rdata, 8'h01);
        check("R11 no pulse during restart", cnt_en, 0);
        @(negedge clk); #1;
        check("R3 restart self clears", rdata, 8'h00);
        check("R3 pulses resume", cnt_en, 1);
    endtask

    task automatic t_divide(input logic [2:0] sel, input int n, input string req);
        int f, t;
        clk_sel = sel;
        bus_wr(CTRL, 8'h01);
        count(n + 1, f, t);
        check({req, " first strobe"}, f, n);
        check({req, " strobe count"}, t, 1);
        @(negedge clk);
        count(n, f, t);
        check({req, " period"}, f, n - 1);
    endtask

    task automatic t_hold_release;
        int f, t;
        clk_sel = 3'b001;
        bus_wr(CTRL, 8'h81);
        count(20, f, t);
        check("R4 hold readback", rdata, 8'h81);
        check("R11 no sys pulses in hold", t, 0);
        clk_sel = 3'b111;
        toggle_ext(3, t);
        check("R11 no ext pulses in hold", t, 0);
        clk_sel = 3'b010;
        bus_wr(CTRL, 8'h00);
        #1;
        check("R5 release readback", rdata, 8'h00);
        count(16, f, t);
        check("R5 first strobe after release", f, 7);
        check("R5 strobe count", t, 2);
    endtask

    task automatic t_collision;
        int f, t;
        clk_sel = 3'b001;
        @(negedge clk);
        wr_en = 1'b1; addr = CTRL; wdata = 8'h01;
        @(negedge clk);
        wdata = 8'h81;
        @(negedge clk);
        wr_en = 1'b0;
        count(10, f, t);
        check("R6 write beats auto clear", rdata, 8'h81);
        check("R6 no pulses", t, 0);
        bus_wr(CTRL, 8'h01);
        #1;
        check("R6 hold dropped by write", rdata, 8'h01);
        @(negedge clk); #1;
        check("R3 clear after hold exit", rdata, 8'h00);
    endtask

    task automatic t_ext;
        int f, t;
        ext_clk = 1'b0;
        clk_sel = 3'b111;
        repeat (4) @(negedge clk);
        ext_clk = 1'b1;
        count(6, f, t);
        check("R9 rise latency", f, 2);
        check("R9 one pulse per rise", t, 1);
        @(negedge clk);
        ext_clk = 1'b0;
        count(6, f, t);
        check("R9 falling ignored in rise mode", t, 0);
        clk_sel = 3'b110;
        @(negedge clk);
        ext_clk = 1'b1;
        count(6, f, t);
        check("R9 rising ignored in fall mode", t, 0);
        @(negedge clk);
        ext_clk = 1'b0;
        count(6, f, t);
        check("R9 fall latency", f, 2);
        clk_sel = 3'b111;
        @(negedge clk);
        toggle_ext(10, t);
        check("R10 rises undivided", t, 10);
        clk_sel = 3'b110;
        toggle_ext(10, t);
        check("R10 falls undivided", t, 10);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_off_sys();
        t_other_addr();
        t_self_clear();
        t_divide(3'b010, 8,    "R8 div8");
        t_divide(3'b011, 64,   "R8 div64");
        t_divide(3'b100, 256,  "R8 div256");
        t_divide(3'b101, 1024, "R8 div1024");
        t_hold_release();
        t_collision();
        t_ext();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule